// File: doc/BRIEF.md
# Window Watchdog with Lead Time

This block supervises a host processor. A slow tick, one clock cycle wide, comes from an adjustable oscillator. After any reset the block gives the host a long lead period in which to deliver its first trigger. Once a trigger arrives, the block cycles through two windows. The first is a closed window, where a trigger counts as a fault. The second is an open window, where a trigger is expected and restarts the cycle.

A fault drives a fixed-length active-low reset pulse. Three things count as a fault: a trigger that arrives too early, a lead period that ends with no trigger, and an open window that ends with no trigger.

The host can trigger through either of two pins. One pin acts on its rising edge and the other on its falling edge. Each pin passes through a synchroniser and a minimum-width filter, so short glitches are not counted.

An undervoltage request from an external supply monitor drives the same reset output. That reset lasts while the request is raised and for a programmable number of ticks after the request drops. The lead period starts only when this reset releases.

The watchdog is held idle in two cases: when the debug input is high, and when the transceiver is not in an active mode. It then restarts with a fresh lead period.

Top module: `wdg_window_watchdog`

## Requirements
- R1: After the synchronous reset, `rst_n_o` is 0. It rises on the UV_HOLD-th tick after the reset ends.
- R2: While `uv_low_i` is 1, `rst_n_o` goes low at the next clock edge and stays low. After `uv_low_i` returns to 0, `rst_n_o` stays low until the UV_HOLD-th following tick.
- R3: Every release of the reset output starts a lead period, whether the reset came from undervoltage or from the watchdog. If no trigger arrives, a watchdog pulse begins on the LEAD_T-th tick after the release.
- R4: A watchdog pulse holds `rst_n_o` low for exactly PULSE_T ticks. Triggers during the pulse have no effect.
- R5: A trigger is valid only in two cases: a rising edge of `trig_pos_i` (idle level 0), or a falling edge of `trig_neg_i` (idle level 1). In both cases the new level must be held for at least MIN_W clock cycles after synchronisation. Shorter pulses are ignored.
- R6: A valid trigger during the lead period ends the lead period and starts a closed window of CLOSED_T ticks.
- R7: A valid trigger during a closed window starts a watchdog pulse at once, within two clock cycles of the filter accepting it.
- R8: A valid trigger during the open window (OPEN_T ticks after the closed window) restarts the closed window. If no trigger arrives, a watchdog pulse begins on the last tick of the open window.
- R9: While `dbg_off_i` is 1, no watchdog pulse is produced and the sequence is held at the start of the lead period. When `dbg_off_i` falls, a full lead period starts.
- R10: While `active_i` is 0, the behaviour is the same as for R9. Triggers are ignored, and a full lead period starts when `active_i` returns to 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| tick_i | input | 1 | One-cycle timebase pulse from the watchdog oscillator |
| trig_pos_i | input | 1 | Trigger input, acts on its rising edge |
| trig_neg_i | input | 1 | Trigger input, acts on its falling edge |
| active_i | input | 1 | 1 when the transceiver is in an active mode (watchdog allowed to run) |
| dbg_off_i | input | 1 | 1 disables the watchdog for debugging |
| uv_low_i | input | 1 | Undervoltage request from the supply monitor |
| rst_n_o | output | 1 | Combined active-low reset, registered |

## Verification
The sequencer's state is visible only through the timing of falls on `rst_n_o`. A wrong state therefore shows up as a pulse at the wrong tick, or as a pulse that is missing or unexpected. Each expected pulse is scored on the tick count at its fall and on its length in ticks.

- A dropped trigger shows up at the end of the next window, within one window length.
- A misclassified window shows up within two clock cycles of the trigger.
- A wrong count on the hold or pulse timer shows up as a length error at the rising edge.

// File: rtl/wdg_pkg.sv
`timescale 1ns/1ps
package wdg_pkg;

  typedef enum logic [1:0] {
    WD_LEAD   = 2'd0,
    WD_CLOSED = 2'd1,
    WD_OPEN   = 2'd2,
    WD_PULSE  = 2'd3
  } wd_state_e;

  function automatic int unsigned max_of4(input int unsigned a, input int unsigned b,
                                          input int unsigned c, input int unsigned d);
    int unsigned m;
    m = a;
    if (b > m) m = b;
    if (c > m) m = c;
    if (d > m) m = d;
    return m;
  endfunction

endpackage

// File: rtl/wdg_trig_filter.sv
`timescale 1ns/1ps
module wdg_trig_filter #(
  parameter int unsigned SYNC     = 2,
  parameter int unsigned MIN_W    = 4,
  parameter bit          ACT_RISE = 1'b1
) (
  input  logic clk,
  input  logic rst,
  input  logic din,
  output logic evt
);
  localparam logic        IDLE_LVL = ACT_RISE ? 1'b0 : 1'b1;
  localparam int unsigned FW       = $clog2(MIN_W + 1);

  logic [SYNC-1:0] sync_q;
  logic            lvl;
  logic            flt_q;
  logic [FW-1:0]   cnt_q;
  logic            evt_q;

  // Synchroniser chain, reset to the idle level so no edge is seen at start.
  always_ff @(posedge clk) begin
    if (rst) sync_q <= {SYNC{IDLE_LVL}};
    else     sync_q <= {sync_q[SYNC-2:0], din};
  end
  assign lvl = sync_q[SYNC-1];

  // Width filter: the new level must persist MIN_W cycles to be accepted.
  always_ff @(posedge clk) begin
    if (rst) begin
      flt_q <= IDLE_LVL;
      cnt_q <= '0;
      evt_q <= 1'b0;
    end else begin
      evt_q <= 1'b0;
      if (lvl != flt_q) begin
        if (cnt_q == FW'(MIN_W - 1)) begin
          flt_q <= lvl;
          cnt_q <= '0;
          evt_q <= (lvl != IDLE_LVL);
        end else begin
          cnt_q <= cnt_q + 1'b1;
        end
      end else begin
        cnt_q <= '0;
      end
    end
  end
  assign evt = evt_q;

  AST_EVT_SINGLE: assert property (@(posedge clk) disable iff (rst) evt_q |=> !evt_q); // R5

endmodule

// File: rtl/wdg_tick_timer.sv
`timescale 1ns/1ps
module wdg_tick_timer #(
  parameter int unsigned W       = 12,
  parameter int unsigned RST_VAL = 1
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         tick,
  input  logic         load,
  input  logic [W-1:0] load_val,
  output logic         expire
);
  logic [W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst)                        cnt_q <= W'(RST_VAL);
    else if (load)                  cnt_q <= load_val;
    else if (tick && cnt_q != '0)   cnt_q <= cnt_q - 1'b1;
  end

  // The N-th tick after a load of N ends the interval.
  assign expire = tick && (cnt_q == W'(1));

endmodule

// File: rtl/wdg_seq_fsm.sv
`timescale 1ns/1ps
module wdg_seq_fsm
  import wdg_pkg::*;
#(
  parameter int unsigned LEAD_T   = 3922,
  parameter int unsigned CLOSED_T = 800,
  parameter int unsigned OPEN_T   = 840,
  parameter int unsigned PULSE_T  = 157
) (
  input  logic clk,
  input  logic rst,
  input  logic tick,
  input  logic trig,
  input  logic run,
  output logic pulse_nxt
);
  localparam int unsigned MAX_T = max_of4(LEAD_T, CLOSED_T, OPEN_T, PULSE_T);
  localparam int unsigned TW    = $clog2(MAX_T + 1);

  wd_state_e     state_q, state_d;
  logic          ld;
  logic [TW-1:0] lv;
  logic          tmr_exp;

  wdg_tick_timer #(.W(TW), .RST_VAL(LEAD_T)) u_win (
    .clk      (clk),
    .rst      (rst),
    .tick     (tick),
    .load     (ld),
    .load_val (lv),
    .expire   (tmr_exp)
  );

  always_comb begin
    state_d = state_q;
    ld      = 1'b0;
    lv      = TW'(LEAD_T);
    if (!run) begin
      state_d = WD_LEAD;
      ld      = 1'b1;
    end else begin
      unique case (state_q)
        WD_LEAD: begin
          if (trig) begin
            state_d = WD_CLOSED; ld = 1'b1; lv = TW'(CLOSED_T);
          end else if (tmr_exp) begin
            state_d = WD_PULSE;  ld = 1'b1; lv = TW'(PULSE_T);
          end
        end
        WD_CLOSED: begin
          if (trig) begin
            state_d = WD_PULSE;  ld = 1'b1; lv = TW'(PULSE_T);
          end else if (tmr_exp) begin
            state_d = WD_OPEN;   ld = 1'b1; lv = TW'(OPEN_T);
          end
        end
        WD_OPEN: begin
          if (trig) begin
            state_d = WD_CLOSED; ld = 1'b1; lv = TW'(CLOSED_T);
          end else if (tmr_exp) begin
            state_d = WD_PULSE;  ld = 1'b1; lv = TW'(PULSE_T);
          end
        end
        WD_PULSE: begin
          if (tmr_exp) begin
            state_d = WD_LEAD;   ld = 1'b1; lv = TW'(LEAD_T);
          end
        end
        default: begin
          state_d = WD_LEAD; ld = 1'b1;
        end
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) state_q <= WD_LEAD;
    else     state_q <= state_d;
  end

  assign pulse_nxt = (state_d == WD_PULSE);

  AST_EARLY_TRIG:  assert property (@(posedge clk) disable iff (rst) (state_q == WD_CLOSED && trig && run) |=> (state_q == WD_PULSE)); // R7
  AST_OPEN_TRIG:   assert property (@(posedge clk) disable iff (rst) (state_q == WD_OPEN && trig && run) |=> (state_q == WD_CLOSED)); // R8
  AST_PULSE_KEEP:  assert property (@(posedge clk) disable iff (rst) (state_q == WD_PULSE && run && !tick) |=> (state_q == WD_PULSE)); // R4
  AST_IDLE_LEAD:   assert property (@(posedge clk) disable iff (rst) !run |=> (state_q == WD_LEAD)); // R9

endmodule

// File: rtl/wdg_window_watchdog.sv
`timescale 1ns/1ps
module wdg_window_watchdog #(
  parameter int unsigned LEAD_T   = 3922,
  parameter int unsigned CLOSED_T = 800,
  parameter int unsigned OPEN_T   = 840,
  parameter int unsigned PULSE_T  = 157,
  parameter int unsigned UV_HOLD  = 800,
  parameter int unsigned MIN_W    = 375,
  parameter int unsigned SYNC     = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic tick_i,
  input  logic trig_pos_i,
  input  logic trig_neg_i,
  input  logic active_i,
  input  logic dbg_off_i,
  input  logic uv_low_i,
  output logic rst_n_o
);
  localparam int unsigned NTRIG_IN = 2;
  localparam int unsigned UW       = $clog2(UV_HOLD + 1);

  logic [NTRIG_IN-1:0] trig_raw;
  logic [NTRIG_IN-1:0] trig_evt;
  logic                trig_any;
  logic                wd_act;
  logic                hold_q, hold_d;
  logic                uv_exp;
  logic                run;
  logic                pulse_nxt;
  logic                rst_n_q;

  assign trig_raw = {trig_neg_i, trig_pos_i};

  // Index 0 acts on a rising edge, index 1 on a falling edge.
  for (genvar g = 0; g < NTRIG_IN; g++) begin : g_trig
    wdg_trig_filter #(
      .SYNC     (SYNC),
      .MIN_W    (MIN_W),
      .ACT_RISE (g == 0)
    ) u_flt (
      .clk (clk),
      .rst (rst),
      .din (trig_raw[g]),
      .evt (trig_evt[g])
    );
  end

  assign trig_any = |trig_evt;

  // Undervoltage hold: reloaded while the request is raised, then counts ticks.
  wdg_tick_timer #(.W(UW), .RST_VAL(UV_HOLD)) u_uv (
    .clk      (clk),
    .rst      (rst),
    .tick     (tick_i),
    .load     (uv_low_i),
    .load_val (UW'(UV_HOLD)),
    .expire   (uv_exp)
  );

  always_comb begin
    hold_d = hold_q;
    if (uv_low_i)              hold_d = 1'b1;
    else if (hold_q && uv_exp) hold_d = 1'b0;
  end

  always_ff @(posedge clk) begin
    if (rst) hold_q <= 1'b1;
    else     hold_q <= hold_d;
  end

  assign wd_act = active_i && !dbg_off_i;
  assign run    = wd_act && !hold_q;

  wdg_seq_fsm #(
    .LEAD_T   (LEAD_T),
    .CLOSED_T (CLOSED_T),
    .OPEN_T   (OPEN_T),
    .PULSE_T  (PULSE_T)
  ) u_seq (
    .clk       (clk),
    .rst       (rst),
    .tick      (tick_i),
    .trig      (trig_any),
    .run       (run),
    .pulse_nxt (pulse_nxt)
  );

  always_ff @(posedge clk) begin
    if (rst) rst_n_q <= 1'b0;
    else     rst_n_q <= !(pulse_nxt || hold_d);
  end
  assign rst_n_o = rst_n_q;

  AST_UV_FORCE:     assert property (@(posedge clk) disable iff (rst) uv_low_i |=> !rst_n_q); // R2
  AST_RISE_ON_TICK: assert property (@(posedge clk) disable iff (rst) $rose(rst_n_q) |-> ($past(tick_i) || $past(!wd_act))); // R4

endmodule

// File: tb/wdg_window_watchdog_test.sv
`timescale 1ns/1ps
module wdg_window_watchdog_test;
  localparam int LEAD   = 40;
  localparam int CLOSED = 10;
  localparam int OPEN   = 12;
  localparam int PULSE  = 5;
  localparam int UVH    = 8;
  localparam int MINW   = 4;
  localparam int TDIV   = 4;

  typedef struct {
    int    lo;
    int    hi;
    int    len;
    string tag;
  } exp_t;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic tick_i = 1'b0;
  logic trig_pos_i = 1'b0;
  logic trig_neg_i = 1'b1;
  logic active_i = 1'b1;
  logic dbg_off_i = 1'b0;
  logic uv_low_i = 1'b0;
  logic rst_n_o;

  int   nchk = 0;
  int   nerr = 0;
  int   tcount = 0;
  int   div = 0;
  int   falls = 0;
  exp_t q[$];

  always #4 clk = ~clk;

  wdg_window_watchdog #(
    .LEAD_T(LEAD), .CLOSED_T(CLOSED), .OPEN_T(OPEN), .PULSE_T(PULSE),
    .UV_HOLD(UVH), .MIN_W(MINW), .SYNC(2)
  ) uut (
    .clk(clk), .rst(rst), .tick_i(tick_i), .trig_pos_i(trig_pos_i),
    .trig_neg_i(trig_neg_i), .active_i(active_i), .dbg_off_i(dbg_off_i),
    .uv_low_i(uv_low_i), .rst_n_o(rst_n_o)
  );

  // Timebase: one-cycle tick every TDIV clocks, changed away from the sampling edge.
  always @(negedge clk) begin
    if (rst) begin
      div = 0;
      tick_i <= 1'b0;
    end else begin
      tick_i <= (div == TDIV - 1);
      div = (div + 1) % TDIV;
    end
  end

  // Count the ticks the design sees.
  always @(posedge clk) begin
    if (rst)         tcount <= 0;
    else if (tick_i) tcount <= tcount + 1;
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    nchk++;
    if (!ok) begin
      nerr++;
      $display("FAIL %s: actual=%0d expected=%0d (t=%0t)", req, act, exp, $time);
    end
  endtask

  // Monitor: pops one expected pulse per fall of the reset output.
  bit   prev_lvl = 1'b0;
  bit   have_cur = 1'b0;
  int   fall_t = 0;
  exp_t cur;
  always @(negedge clk) begin
    if (rst) begin
      prev_lvl = 1'b0;
      have_cur = 1'b0;
    end else begin
      if (prev_lvl && !rst_n_o) begin
        falls++;
        if (q.size() == 0) begin
          check(1'b0, "R9 R10 unexpected pulse", tcount, -1);
        end else begin
          cur = q.pop_front();
          have_cur = 1'b1;
          fall_t = tcount;
          check(tcount >= cur.lo && tcount <= cur.hi, cur.tag, tcount, cur.lo);
        end
      end
      if (!prev_lvl && rst_n_o && have_cur) begin
        check((tcount - fall_t) == cur.len, cur.tag, tcount - fall_t, cur.len);
        have_cur = 1'b0;
      end
      prev_lvl = rst_n_o;
    end
  end

  task automatic push_exp(input int lo, input int hi, input int len, input string tag);
    exp_t e;
    e.lo = lo; e.hi = hi; e.len = len; e.tag = tag;
    q.push_back(e);
  endtask

  task automatic wait_until(input int t);
    while (tcount < t) @(negedge clk);
  endtask

  task automatic wait_done();
    @(negedge clk);
    while (q.size() != 0 || !rst_n_o || have_cur) @(negedge clk);
  endtask

  task automatic pulse_pos(input int w);
    trig_pos_i = 1'b1;
    repeat (w) @(negedge clk);
    trig_pos_i = 1'b0;
    repeat (w) @(negedge clk);
  endtask

  task automatic pulse_neg(input int w);
    trig_neg_i = 1'b0;
    repeat (w) @(negedge clk);
    trig_neg_i = 1'b1;
    repeat (w) @(negedge clk);
  endtask

  task automatic finish_run();
    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    check(1'b0, "watchdog expired", 0, 1);
    finish_run();
  end

  initial begin
    int k;
    int f0;
    repeat (5) @(negedge clk);
    check(rst_n_o == 1'b0, "R1 reset state", rst_n_o, 0);
    rst = 1'b0;
    @(negedge clk);
    check(rst_n_o == 1'b0, "R1 hold after reset", rst_n_o, 0);
    while (!rst_n_o) @(negedge clk);
    check(tcount == UVH, "R1 release tick", tcount, UVH);

    // Lead period with no trigger, then the lead restarts after the pulse.
    push_exp(UVH + LEAD, UVH + LEAD, PULSE, "R3 lead expiry");
    wait_done();
    push_exp(tcount + LEAD, tcount + LEAD, PULSE, "R3 lead after watchdog pulse");
    wait_done();

    // Trigger in lead, restart in open, closed-window glitch, restart again.
    wait_until(tcount + 5);
    k = tcount;
    pulse_pos(2 * MINW);                   // R6 trigger ends the lead
    wait_until(k + 16);
    k = tcount;
    pulse_neg(2 * MINW);                   // R8 falling-edge trigger in open window
    wait_until(k + 4);
    trig_pos_i = 1'b1;                     // R5 short glitch in closed window
    repeat (2) @(negedge clk);
    trig_pos_i = 1'b0;
    wait_until(k + 15);
    k = tcount;
    push_exp(k + 21, k + 24, PULSE, "R6 R8 open window expiry");
    pulse_pos(2 * MINW);
    wait_done();

    // Early trigger in the closed window; trigger during the pulse is ignored.
    wait_until(tcount + 3);
    k = tcount;
    pulse_pos(2 * MINW);
    wait_until(k + 5);
    k = tcount;
    push_exp(k, k + 2, PULSE, "R7 R4 closed-window trigger");
    trig_neg_i = 1'b0;
    while (rst_n_o) @(negedge clk);
    trig_neg_i = 1'b1;
    repeat (MINW + 4) @(negedge clk);
    pulse_pos(2 * MINW);
    wait_done();

    // Glitch in the open window does not count as a trigger.
    wait_until(tcount + 2);
    k = tcount;
    pulse_pos(2 * MINW);
    wait_until(k + 16);
    push_exp(k + 21, k + 24, PULSE, "R5 open-window glitch ignored");
    trig_neg_i = 1'b0;
    repeat (2) @(negedge clk);
    trig_neg_i = 1'b1;
    wait_done();

    // Debug disable.
    dbg_off_i = 1'b1;
    f0 = falls;
    wait_until(tcount + LEAD + 20);
    check(falls == f0, "R9 no pulse while disabled", falls - f0, 0);
    check(rst_n_o == 1'b1, "R9 output high while disabled", rst_n_o, 1);
    k = tcount;
    dbg_off_i = 1'b0;
    push_exp(k + LEAD, k + LEAD, PULSE, "R9 lead after debug exit");
    wait_done();

    // Inactive mode, with closed-window style triggers that must be ignored.
    active_i = 1'b0;
    f0 = falls;
    pulse_pos(2 * MINW);
    wait_until(tcount + 3);
    pulse_neg(2 * MINW);
    wait_until(tcount + LEAD + 20);
    check(falls == f0, "R10 no pulse while inactive", falls - f0, 0);
    check(rst_n_o == 1'b1, "R10 output high while inactive", rst_n_o, 1);
    k = tcount;
    active_i = 1'b1;
    push_exp(k + LEAD, k + LEAD, PULSE, "R10 lead after wake");
    wait_done();

    // Undervoltage during a closed window, then a fresh lead period.
    wait_until(tcount + 2);
    pulse_pos(2 * MINW);
    wait_until(tcount + 3);
    k = tcount;
    push_exp(k, k, 6 + UVH, "R2 undervoltage hold");
    push_exp(k + 6 + UVH + LEAD, k + 6 + UVH + LEAD, PULSE, "R3 lead after undervoltage");
    uv_low_i = 1'b1;
    wait_until(k + 6);
    uv_low_i = 1'b0;
    wait_done();

    check(q.size() == 0, "R3 all expected pulses seen", q.size(), 0);
    finish_run();
  end

endmodule